// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Packed-BCD Mode

This block is a purely combinational 8-bit arithmetic and logic unit for a small accumulator-style processor core. Each evaluation takes an operation code, a first operand, a second operand, and the incoming carry and decimal-mode flags. The first operand is the accumulator or an index register that the caller has already selected. The block returns an 8-bit result, a result-write strobe, and four status flags: negative, overflow, zero and carry. It also returns a four-bit write-enable mask that says which of those flags the operation updates. Flags outside the mask keep whatever value the surrounding status register already holds.

The supported operations are OR, AND, exclusive-OR, add with carry, subtract with borrow, compare, bit test, increment, decrement, and left or right shifts and rotates. Add and subtract have a packed-BCD mode. In that mode each decimal digit is corrected on its own and the carry is taken from the decimal digit chain. Negative, zero and overflow are still taken from the plain binary sum or difference. Register storage, operand fetch and the status register itself are outside the block.

Top module: `alu8_core`

## Requirements
- R1: Op codes 0, 1 and 2 give `a_i | m_i`, `a_i & m_i` and `a_i ^ m_i`. Each raises `res_we_o` and writes only N and Z, with N = result bit 7 and Z = (result == 0).
- R2: Op 3 with `d_i`=0 gives the low 8 bits of `a_i + m_i + c_i`. C is set when that 9-bit sum exceeds 0xFF.
- R3: Op 4 with `d_i`=0 gives `a_i - m_i - (1 - c_i)` modulo 256. C is set when no borrow occurs.
- R4: For op 3 and op 4, V is set when the signed two's-complement result lies outside -128..127. N and Z come from the 8-bit binary result.
- R5: Op 3 with `d_i`=1 and valid BCD operands adds digit by digit. The low sum is lo(a)+lo(m)+c, and a low sum of 10 or more adds one to the high sum hi(a)+hi(m). Each digit is reduced mod 10, and C is set when the high sum exceeds 9.
- R6: Op 4 with `d_i`=1 and valid BCD operands computes the low value 10+lo(a)-lo(m)+c-1. The high value is 10+hi(a)-hi(m), less one when the low value is below 10. Each digit is reduced mod 10, and C is set when the high value is 10 or more.
- R7: In decimal add and subtract, N, Z and V equal the values that the binary operation on the same inputs would give. Only the result and C differ from binary.
- R8: Op 5 (compare) sets N and Z from `(a_i - m_i)` modulo 256 and sets C when `a_i >= m_i` unsigned. It drives `res_we_o` low and writes only N, Z and C.
- R9: Op 6 (bit test) sets Z when `a_i & m_i` is zero and copies `m_i` bit 7 into N and bit 6 into V. It drives `res_we_o` low and writes only N, V and Z.
- R10: Op 7 and op 8 give `m_i + 1` and `m_i - 1` modulo 256. They write only N and Z.
- R11: Op 9 (shift left), 10 (shift right), 11 (rotate left) and 12 (rotate right) operate on `m_i`. A left move sends bit 7 to C and a right move sends bit 0 to C. A rotate fills the vacated bit with `c_i` and a shift fills it with 0. These ops write N, Z and C.
- R12: `flags_o` and `flag_we_o` use the bit order N=3, V=2, Z=1, C=0. Any flag bit not enabled in `flag_we_o` reads 0.
- R13: Op codes 13, 14 and 15 are reserved. They give `flag_we_o` = 0, `flags_o` = 0 and `res_we_o` = 0.
- R14: `d_i` has no effect on any operation other than op 3 and op 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 8 | First operand: accumulator or selected register |
| m_i | input | 8 | Second operand, and the source for increment, decrement, shift and rotate |
| c_i | input | 1 | Incoming carry flag |
| d_i | input | 1 | Incoming decimal-mode flag |
| res_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | New flag values {N, V, Z, C} |
| flag_we_o | output | 4 | Per-flag write enable {N, V, Z, C} |

## Verification
Uniform random operands over all sixteen op codes exercise the binary paths, the flag masks and the reserved codes. Random valid-BCD operand pairs with the decimal flag set cover the per-digit correction. Comparing those runs against the binary N, Z and V separates the decimal result path from the binary flag path. Directed cases cover the boundaries: signed overflow at 0x50+0x50, carry wrap at 0xFF+1, decimal carry out and decimal borrow to 0x91, and equal and unequal compares. They also cover a bit test whose AND is zero while M has bits 7 and 6 set, and rotates that pull the old carry into the vacated bit. Changing the decimal flag under compare, increment and shifts shows whether the decimal path leaks outside add and subtract.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int DIGITS = DATA_W / NIB_W;
    localparam int WIDE_W = NIB_W + 2;

    typedef enum logic [3:0] {
        OP_OR  = 4'd0,
        OP_AND = 4'd1,
        OP_XOR = 4'd2,
        OP_ADD = 4'd3,
        OP_SUB = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t WE_NONE = 4'b0000;
    localparam flags_t WE_NZ   = 4'b1010;
    localparam flags_t WE_NZC  = 4'b1011;
    localparam flags_t WE_NVZ  = 4'b1110;
    localparam flags_t WE_ALL  = 4'b1111;

    // Reduce a small non-negative value (0..39) to a single decimal digit.
    function automatic logic [NIB_W-1:0] fold_digit(input logic [WIDE_W-1:0] v);
        logic [WIDE_W-1:0] r;
        if (v >= WIDE_W'(30))      r = v - WIDE_W'(30);
        else if (v >= WIDE_W'(20)) r = v - WIDE_W'(20);
        else if (v >= WIDE_W'(10)) r = v - WIDE_W'(10);
        else                       r = v;
        return r[NIB_W-1:0];
    endfunction

    function automatic logic is_arith(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu8_bcd_digit.sv
module alu8_bcd_digit
    import alu8_pkg::*;
(
    input  logic             sub_i,
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] m_i,
    input  logic             link_i,   // carry in (add) or borrow in (sub)
    output logic [NIB_W-1:0] digit_o,
    output logic             link_o    // carry out (add) or borrow out (sub)
);
    logic [WIDE_W-1:0] raw;

    always_comb begin
        if (sub_i) begin
            raw    = WIDE_W'(10) + WIDE_W'(a_i) - WIDE_W'(m_i) - WIDE_W'(link_i);
            link_o = (raw < WIDE_W'(10));
        end else begin
            raw    = WIDE_W'(a_i) + WIDE_W'(m_i) + WIDE_W'(link_i);
            link_o = (raw >= WIDE_W'(10));
        end
        digit_o = fold_digit(raw);
    end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         sub_i,
    input  logic         dec_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o
);
    localparam int ND = W / NIB_W;

    logic [W-1:0]   m_eff;
    logic [W:0]     bin_sum;
    logic [W-1:0]   bin_res;
    logic [W-1:0]   bcd_res;
    logic [ND:0]    link;

    assign m_eff   = sub_i ? ~m_i : m_i;
    assign bin_sum = {1'b0, a_i} + {1'b0, m_eff} + {{W{1'b0}}, c_i};
    assign bin_res = bin_sum[W-1:0];

    assign link[0] = sub_i ? ~c_i : c_i;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        alu8_bcd_digit u_digit (
            .sub_i   (sub_i),
            .a_i     (a_i[g*NIB_W +: NIB_W]),
            .m_i     (m_i[g*NIB_W +: NIB_W]),
            .link_i  (link[g]),
            .digit_o (bcd_res[g*NIB_W +: NIB_W]),
            .link_o  (link[g+1])
        );
    end

    always_comb begin
        n_o = bin_res[W-1];
        z_o = (bin_res == '0);
        v_o = (a_i[W-1] == m_eff[W-1]) && (bin_res[W-1] != a_i[W-1]);
        if (dec_i) begin
            res_o = bcd_res;
            c_o   = sub_i ? ~link[ND] : link[ND];
        end else begin
            res_o = bin_res;
            c_o   = bin_sum[W];
        end
    end

    always_comb begin
        logic ok_in;
        ok_in = 1'b1;
        for (int i = 0; i < ND; i++) begin
            if (a_i[i*NIB_W +: NIB_W] > 4'd9 || m_i[i*NIB_W +: NIB_W] > 4'd9) ok_in = 1'b0;
        end
        for (int i = 0; i < ND; i++) begin
            // R5 R6
            bcd_digit_chk: assert (!(dec_i && ok_in) || res_o[i*NIB_W +: NIB_W] <= 4'd9)
                else $error("decimal digit out of range");
        end
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output flags_t       test_o
);
    always_comb begin
        res_o  = '0;
        c_o    = 1'b0;
        test_o = '0;
        unique case (op_i)
            OP_OR:  res_o = a_i | m_i;
            OP_AND: res_o = a_i & m_i;
            OP_XOR: res_o = a_i ^ m_i;
            OP_INC: res_o = m_i + W'(1);
            OP_DEC: res_o = m_i - W'(1);
            OP_SHL: begin res_o = {m_i[W-2:0], 1'b0}; c_o = m_i[W-1]; end
            OP_ROL: begin res_o = {m_i[W-2:0], c_i};  c_o = m_i[W-1]; end
            OP_SHR: begin res_o = {1'b0, m_i[W-1:1]}; c_o = m_i[0];   end
            OP_ROR: begin res_o = {c_i, m_i[W-1:1]};  c_o = m_i[0];   end
            OP_BIT: begin
                test_o.z = ((a_i & m_i) == '0);
                test_o.n = m_i[W-1];
                test_o.v = m_i[W-2];
            end
            default: res_o = '0;
        endcase
    end

    always_comb begin
        // R10
        incdec_wrap_chk: assert (!((op_i == OP_INC && m_i == '1) || (op_i == OP_DEC && m_i == '0))
                                 || res_o == (op_i == OP_INC ? '0 : '1))
            else $error("increment/decrement wrap wrong");
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] m_i,
    input  logic              c_i,
    input  logic              d_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic [3:0]        flags_o,
    output logic [3:0]        flag_we_o
);
    logic [DATA_W-1:0] as_res, bo_res;
    logic              as_n, as_z, as_c, as_v, bo_c;
    logic              use_sub, use_dec, as_cin;
    flags_t            bo_test, raw_f, mask;

    assign use_sub = (op_i != OP_ADD);
    assign use_dec = d_i && is_arith(op_i);
    assign as_cin  = (op_i == OP_CMP) ? 1'b1 : c_i;

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .sub_i (use_sub),
        .dec_i (use_dec),
        .a_i   (a_i),
        .m_i   (m_i),
        .c_i   (as_cin),
        .res_o (as_res),
        .n_o   (as_n),
        .z_o   (as_z),
        .c_o   (as_c),
        .v_o   (as_v)
    );

    alu8_bitops #(.W(DATA_W)) u_bitops (
        .op_i   (op_i),
        .a_i    (a_i),
        .m_i    (m_i),
        .c_i    (c_i),
        .res_o  (bo_res),
        .c_o    (bo_c),
        .test_o (bo_test)
    );

    always_comb begin
        res_o    = a_i;
        res_we_o = 1'b0;
        raw_f    = '0;
        mask     = WE_NONE;
        unique case (op_i)
            OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC: begin
                res_o    = bo_res;
                res_we_o = 1'b1;
                raw_f.n  = bo_res[DATA_W-1];
                raw_f.z  = (bo_res == '0);
                mask     = WE_NZ;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_o    = bo_res;
                res_we_o = 1'b1;
                raw_f.n  = bo_res[DATA_W-1];
                raw_f.z  = (bo_res == '0);
                raw_f.c  = bo_c;
                mask     = WE_NZC;
            end
            OP_ADD, OP_SUB: begin
                res_o    = as_res;
                res_we_o = 1'b1;
                raw_f    = '{n: as_n, v: as_v, z: as_z, c: as_c};
                mask     = WE_ALL;
            end
            OP_CMP: begin
                raw_f.n  = as_n;
                raw_f.z  = as_z;
                raw_f.c  = as_c;
                mask     = WE_NZC;
            end
            OP_BIT: begin
                raw_f    = bo_test;
                mask     = WE_NVZ;
            end
            default: begin
                mask     = WE_NONE;
            end
        endcase
        flags_o   = raw_f & mask;
        flag_we_o = mask;
    end

    always_comb begin
        // R8
        cmp_carry_chk: assert (op_i != OP_CMP || (flags_o[0] == (a_i >= m_i) && !res_we_o))
            else $error("compare carry or write strobe wrong");
        // R11
        shift_carry_chk: assert (!(op_i inside {OP_SHL, OP_ROL, OP_SHR, OP_ROR})
                                 || flags_o[0] == ((op_i inside {OP_SHL, OP_ROL}) ? m_i[DATA_W-1] : m_i[0]))
            else $error("shift carry source wrong");
        // R13
        reserved_op_chk: assert (op_i <= OP_ROR || (flag_we_o == 4'b0 && !res_we_o))
            else $error("reserved op wrote state");
        // R2
        bin_add_chk: assert (!(op_i == OP_ADD && !d_i)
                             || {flags_o[0], res_o} == ({1'b0, a_i} + {1'b0, m_i} + 9'(c_i)))
            else $error("binary add mismatch");
    end
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a, m;
    logic       c, d;
    logic [7:0] res;
    logic       res_we;
    logic [3:0] flags, flag_we;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .op_i(op), .a_i(a), .m_i(m), .c_i(c), .d_i(d),
        .res_o(res), .res_we_o(res_we), .flags_o(flags), .flag_we_o(flag_we)
    );

    function automatic string req_of(input logic [3:0] o, input logic dm);
        case (o)
            0, 1, 2: return "R1";
            3: return dm ? "R5" : "R2";
            4: return dm ? "R6" : "R3";
            5: return "R8";
            6: return "R9";
            7, 8: return "R10";
            9, 10, 11, 12: return "R11";
            default: return "R13";
        endcase
    endfunction

    // Reference: returns {res[7:0], res_we, flags[3:0] (N V Z C), mask[3:0]}
    function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] x,
                                          input logic [7:0] y, input logic ci, input logic dm);
        int t, st, lo, hi;
        logic [7:0] r = x, tr;
        logic we = 1'b0, fn = 0, fv = 0, fz = 0, fc = 0;
        logic [3:0] mk = 4'b0000;
        case (o)
            0, 1, 2, 7, 8: begin
                r = (o == 0) ? (x | y) : (o == 1) ? (x & y) : (o == 2) ? (x ^ y)
                  : (o == 7) ? 8'(y + 1) : 8'(y - 1);
                we = 1; fn = r[7]; fz = (r == 0); mk = 4'b1010;
            end
            9, 10, 11, 12: begin
                if (o == 9 || o == 11) begin fc = y[7]; r = {y[6:0], (o == 11) ? ci : 1'b0}; end
                else begin fc = y[0]; r = {(o == 12) ? ci : 1'b0, y[7:1]}; end
                we = 1; fn = r[7]; fz = (r == 0); mk = 4'b1011;
            end
            3: begin
                t = int'(x) + int'(y) + int'(ci);
                st = int'($signed(x)) + int'($signed(y)) + int'(ci);
                tr = 8'(t); r = tr; fc = (t > 255);
                if (dm) begin
                    lo = int'(x[3:0]) + int'(y[3:0]) + int'(ci);
                    hi = int'(x[7:4]) + int'(y[7:4]) + ((lo >= 10) ? 1 : 0);
                    r = 8'(((hi % 10) << 4) | (lo % 10)); fc = (hi > 9);
                end
                we = 1; fn = tr[7]; fz = (tr == 0); fv = (st < -128 || st > 127); mk = 4'b1111;
            end
            4: begin
                t = 256 + int'(x) - int'(y) + int'(ci) - 1;
                st = int'($signed(x)) - int'($signed(y)) + int'(ci) - 1;
                tr = 8'(t); r = tr; fc = (t > 255);
                if (dm) begin
                    lo = 10 + int'(x[3:0]) - int'(y[3:0]) + int'(ci) - 1;
                    hi = 10 + int'(x[7:4]) - int'(y[7:4]) - ((lo < 10) ? 1 : 0);
                    r = 8'(((hi % 10) << 4) | (lo % 10)); fc = (hi >= 10);
                end
                we = 1; fn = tr[7]; fz = (tr == 0); fv = (st < -128 || st > 127); mk = 4'b1111;
            end
            5: begin
                tr = 8'(x - y); fn = tr[7]; fz = (tr == 0); fc = (x >= y); mk = 4'b1011;
            end
            6: begin
                fz = ((x & y) == 0); fn = y[7]; fv = y[6]; mk = 4'b1110;
            end
            default: ;
        endcase
        return {r, we, fn, fv, fz, fc, mk};
    endfunction

    task automatic run(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic ci, input logic dm, input string tag);
        logic [16:0] exp, act;
        @(negedge clk);
        op = o; a = x; m = y; c = ci; d = dm;
        @(posedge clk);
        #1;
        exp = model(o, x, y, ci, dm);
        act = {res, res_we, flags, flag_we};
        if (exp[8] == 1'b0) act[16:9] = exp[16:9]; // result content unused when not written
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h m=%h c=%b d=%b: res=%h we=%b flags=%b mask=%b, expected res=%h we=%b flags=%b mask=%b",
                     tag, o, x, y, ci, dm, res, res_we, flags, flag_we,
                     exp[16:9], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    function automatic logic [7:0] rnd_bcd();
        return {4'($urandom % 10), 4'($urandom % 10)};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] o;
        logic       dm;
        void'($urandom(32'd20240611));
        op = 0; a = 0; m = 0; c = 0; d = 0;
        // R1 R12: all-zero starting inputs
        run(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R1/R12 zero");
        // R4 signed overflow, R2 carry wrap
        run(4'd3, 8'h50, 8'h50, 1'b0, 1'b0, "R4 overflow");
        run(4'd3, 8'hFF, 8'h01, 1'b0, 1'b0, "R2 wrap");
        run(4'd4, 8'h80, 8'h01, 1'b1, 1'b0, "R3/R4 sub overflow");
        run(4'd4, 8'h00, 8'h01, 1'b1, 1'b0, "R3 borrow");
        // R5 R6 R7 decimal
        run(4'd3, 8'h58, 8'h46, 1'b1, 1'b1, "R5 carry out");
        run(4'd3, 8'h99, 8'h00, 1'b1, 1'b1, "R5/R7 to zero");
        run(4'd4, 8'h46, 8'h12, 1'b1, 1'b1, "R6 plain");
        run(4'd4, 8'h12, 8'h21, 1'b1, 1'b1, "R6 borrow");
        run(4'd4, 8'h40, 8'h13, 1'b0, 1'b1, "R6/R7 low borrow");
        // R8 compare
        run(4'd5, 8'h42, 8'h42, 1'b0, 1'b0, "R8 equal");
        run(4'd5, 8'h10, 8'h20, 1'b1, 1'b0, "R8 less");
        // R9 bit test
        run(4'd6, 8'h00, 8'hC0, 1'b0, 1'b0, "R9 zero and");
        run(4'd6, 8'h01, 8'h3F, 1'b0, 1'b0, "R9 nonzero");
        // R10 wrap
        run(4'd7, 8'h00, 8'hFF, 1'b0, 1'b0, "R10 inc wrap");
        run(4'd8, 8'h00, 8'h00, 1'b0, 1'b0, "R10 dec wrap");
        // R11 shifts
        run(4'd12, 8'h00, 8'h01, 1'b1, 1'b0, "R11 ror");
        run(4'd11, 8'h00, 8'h80, 1'b1, 1'b0, "R11 rol");
        run(4'd10, 8'h00, 8'h01, 1'b1, 1'b0, "R11 lsr");
        run(4'd9, 8'h00, 8'hC1, 1'b1, 1'b0, "R11 asl");
        // R13 reserved
        run(4'd13, 8'hFF, 8'hFF, 1'b1, 1'b1, "R13 op13");
        run(4'd15, 8'h00, 8'h00, 1'b0, 1'b0, "R13 op15");
        // R14 decimal flag outside add/sub
        run(4'd5, 8'h19, 8'h0A, 1'b0, 1'b1, "R14 cmp");
        run(4'd7, 8'h00, 8'h09, 1'b0, 1'b1, "R14 inc");
        run(4'd9, 8'h00, 8'h99, 1'b0, 1'b1, "R14 asl");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            o  = 4'($urandom % 16);
            dm = 1'($urandom);
            if (dm && (o == 4'd3 || o == 4'd4))
                run(o, rnd_bcd(), rnd_bcd(), 1'($urandom), 1'b1, req_of(o, 1'b1));
            else if (dm)
                run(o, 8'($urandom), 8'($urandom), 1'($urandom), 1'b1, "R14 random");
            else
                run(o, 8'($urandom), 8'($urandom), 1'($urandom), 1'b0, req_of(o, 1'b0));
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule